// File: doc/BRIEF.md
# SPI Word FIFOs with Interrupt and DMA Request Generation

This block holds the transmit and receive word queues of an SPI master and turns their fill levels into one interrupt line and three DMA request lines. A small register port lets software or a DMA engine do five things: push transmit words, pop receive words, set interrupt and DMA enables, program the watermarks, and read a status word. The receive-ready status bit is there so that software can drain the receive queue by reading until that bit clears.

On the serial side, a shift-exchange stub stands in for the real shifter. Each exchange pulse takes one word off the transmit queue and stores one word in the receive queue. The received word is either the word from the serial input or, in loopback, the transmitted word itself. An exchange with an empty transmit queue does nothing. Serial clock generation and chip-select timing are outside this block.

All requests are level based. The transmit request stays high while the transmit level is at or below its watermark. The receive request stays high while the receive level is at or above its watermark. The receive-tail request lets a DMA engine collect leftover words once the transmit side has run dry.

Top module: `spi_fifo_irq_dma`

## Requirements
- R1: After reset both queues are empty and every enable is 0. All three watermarks are 32 (half of the 64-word depth), so the DMA register (address 4) reads 0x2020_0020. Status (address 3) reads 0x1, and irq_o and all DMA requests are low.
- R2: Words written to the transmit data register (address 1) leave in write order. tx_word_o shows the oldest word, and each exchange pulse removes one word.
- R3: A write to address 1 while the transmit queue holds 64 words is dropped and sets a sticky overflow flag at status bit 7. Writing 1 to status bit 7 clears the flag.
- R4: Reading the receive data register (address 0) returns the oldest received word and removes it. A read while the queue is empty returns 0 and changes nothing.
- R5: Status bit 3 is 1 while the receive queue holds at least one word and 0 otherwise. Status bit 0 is 1 while the transmit queue is empty.
- R6: irq_o is high while one of two conditions holds: interrupt-enable bit 0 (address 2) is set and the transmit queue is empty, or interrupt-enable bit 3 is set and the receive queue is not empty.
- R7: tx_dma_req_o is high while DMA bit 7 is set and the transmit level is at or below the watermark in DMA bits [5:0].
- R8: rx_dma_req_o is high while DMA bit 23 is set and the receive level is at or above the watermark in DMA bits [21:16].
- R9: rxt_dma_req_o is high while all of these hold: DMA bit 31 is set, the transmit queue is empty, the receive queue is not empty, and the receive level is at or above the tail watermark in DMA bits [29:24].
- R10: With loopback bit 0 (address 5) set, each exchange stores the transmitted word in the receive queue and rx_word_i is ignored.
- R11: An exchange pulse while the transmit queue is empty is ignored: nothing is popped and nothing is stored.
- R12: An exchange while the receive queue holds 64 words still pops the transmit word, but the received word is dropped and the receive level stays at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on address 0) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register, combinational |
| xchg_i | input | 1 | One-cycle pulse marking a completed serial exchange |
| rx_word_i | input | 32 | Word received from the serial line |
| tx_word_o | output | 32 | Oldest transmit word (0 when the queue is empty) |
| irq_o | output | 1 | Level interrupt |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| rxt_dma_req_o | output | 1 | Receive-tail DMA request |

## Verification
Register writes, transmit pushes, receive pops and exchanges all take effect at the clock edge that samples the strobe. irq_o, the DMA requests, the status bits and tx_word_o are decoded combinationally from registered state, so each is due in the same cycle that follows that edge, with no further delay. Read data is combinational from the state before the edge that performs the pop. The bench raises a strobe at a falling edge, samples read data one time unit later, and checks the other outputs at the next falling edge, after exactly one rising edge has passed.

// File: rtl/sfid_pkg.sv
package sfid_pkg;
  localparam int WM_W = 6;

  localparam logic [2:0] A_RXD  = 3'd0;
  localparam logic [2:0] A_TXD  = 3'd1;
  localparam logic [2:0] A_IEN  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_DMA  = 3'd4;
  localparam logic [2:0] A_LOOP = 3'd5;

  localparam int IEN_TXE = 0;
  localparam int IEN_RXR = 3;
  localparam int ST_TXE  = 0;
  localparam int ST_RXR  = 3;
  localparam int ST_OVF  = 7;

  localparam int DMA_TXWM  = 0;
  localparam int DMA_TXEN  = 7;
  localparam int DMA_RXWM  = 16;
  localparam int DMA_RXEN  = 23;
  localparam int DMA_RXTWM = 24;
  localparam int DMA_RXTEN = 31;

  typedef struct packed {
    logic            tx_en;
    logic            rx_en;
    logic            rxt_en;
    logic [WM_W-1:0] tx_wm;
    logic [WM_W-1:0] rx_wm;
    logic [WM_W-1:0] rxt_wm;
  } dma_cfg_t;
endpackage

// File: rtl/sfid_fifo.sv
module sfid_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level;
  logic             do_push, do_pop;

  assign full_o  = (level == LVL_W'(DEPTH));
  assign empty_o = (level == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem[rd_ptr];
  assign level_o = level;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sfid_regs.sv
module sfid_regs
  import sfid_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam logic [WM_W-1:0] WM_RST = WM_W'(DEPTH / 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    addr_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tx_full_i,
  input  logic          tx_empty_i,
  input  logic          rx_empty_i,
  input  logic [DW-1:0] rx_head_i,
  output logic          tx_push_o,
  output logic          rx_pop_o,
  output logic          ien_txe_o,
  output logic          ien_rxr_o,
  output logic          loop_o,
  output dma_cfg_t      dma_o
);
  logic     ien_txe, ien_rxr, loop_q, ovf_q;
  dma_cfg_t dma_q;
  logic     wr_ien, wr_dma, wr_loop, wr_stat;

  assign wr_ien    = we_i & (addr_i == A_IEN);
  assign wr_dma    = we_i & (addr_i == A_DMA);
  assign wr_loop   = we_i & (addr_i == A_LOOP);
  assign wr_stat   = we_i & (addr_i == A_STAT);
  assign tx_push_o = we_i & (addr_i == A_TXD);
  assign rx_pop_o  = re_i & (addr_i == A_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_txe <= 1'b0;
      ien_rxr <= 1'b0;
      loop_q  <= 1'b0;
      ovf_q   <= 1'b0;
      dma_q   <= '{tx_en: 1'b0, rx_en: 1'b0, rxt_en: 1'b0,
                   tx_wm: WM_RST, rx_wm: WM_RST, rxt_wm: WM_RST};
    end else begin
      if (wr_ien) begin
        ien_txe <= wdata_i[IEN_TXE];
        ien_rxr <= wdata_i[IEN_RXR];
      end
      if (wr_loop) loop_q <= wdata_i[0];
      if (wr_dma) begin
        dma_q.tx_en  <= wdata_i[DMA_TXEN];
        dma_q.rx_en  <= wdata_i[DMA_RXEN];
        dma_q.rxt_en <= wdata_i[DMA_RXTEN];
        dma_q.tx_wm  <= wdata_i[DMA_TXWM  +: WM_W];
        dma_q.rx_wm  <= wdata_i[DMA_RXWM  +: WM_W];
        dma_q.rxt_wm <= wdata_i[DMA_RXTWM +: WM_W];
      end
      // set wins over a same-cycle clear
      if (tx_push_o & tx_full_i)            ovf_q <= 1'b1;
      else if (wr_stat & wdata_i[ST_OVF])   ovf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_RXD:  rdata_o = rx_empty_i ? '0 : rx_head_i;
      A_IEN: begin
        rdata_o[IEN_TXE] = ien_txe;
        rdata_o[IEN_RXR] = ien_rxr;
      end
      A_STAT: begin
        rdata_o[ST_TXE] = tx_empty_i;
        rdata_o[ST_RXR] = ~rx_empty_i;
        rdata_o[ST_OVF] = ovf_q;
      end
      A_DMA: begin
        rdata_o[DMA_TXEN]              = dma_q.tx_en;
        rdata_o[DMA_RXEN]              = dma_q.rx_en;
        rdata_o[DMA_RXTEN]             = dma_q.rxt_en;
        rdata_o[DMA_TXWM  +: WM_W]     = dma_q.tx_wm;
        rdata_o[DMA_RXWM  +: WM_W]     = dma_q.rx_wm;
        rdata_o[DMA_RXTWM +: WM_W]     = dma_q.rxt_wm;
      end
      A_LOOP: rdata_o[0] = loop_q;
      default: rdata_o = '0;
    endcase
  end

  assign ien_txe_o = ien_txe;
  assign ien_rxr_o = ien_rxr;
  assign loop_o    = loop_q;
  assign dma_o     = dma_q;
endmodule

// File: rtl/sfid_req.sv
module sfid_req
  import sfid_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic             ien_txe_i,
  input  logic             ien_rxr_i,
  input  dma_cfg_t         dma_i,
  output logic             irq_o,
  output logic             tx_req_o,
  output logic             rx_req_o,
  output logic             rxt_req_o
);
  logic tx_mt, rx_any;

  assign tx_mt  = (tx_lvl_i == '0);
  assign rx_any = (rx_lvl_i != '0);

  assign irq_o     = (ien_txe_i & tx_mt) | (ien_rxr_i & rx_any);
  assign tx_req_o  = dma_i.tx_en & (tx_lvl_i <= LVL_W'(dma_i.tx_wm));
  assign rx_req_o  = dma_i.rx_en & (rx_lvl_i >= LVL_W'(dma_i.rx_wm));
  assign rxt_req_o = dma_i.rxt_en & tx_mt & rx_any &
                     (rx_lvl_i >= LVL_W'(dma_i.rxt_wm));
endmodule

// File: rtl/spi_fifo_irq_dma.sv
module spi_fifo_irq_dma
  import sfid_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    reg_addr_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          xchg_i,
  input  logic [DW-1:0] rx_word_i,
  output logic [DW-1:0] tx_word_o,
  output logic          irq_o,
  output logic          tx_dma_req_o,
  output logic          rx_dma_req_o,
  output logic          rxt_dma_req_o
);
  logic [LVL_W-1:0] tx_level, rx_level;
  logic [DW-1:0]    tx_head, rx_head, rx_in;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_push, rx_pop, xchg_ok;
  logic             ien_txe, ien_rxr, loop_en;
  dma_cfg_t         dma_cfg;

  assign xchg_ok   = xchg_i & ~tx_empty;
  assign rx_in     = loop_en ? tx_head : rx_word_i;
  assign tx_word_o = tx_empty ? '0 : tx_head;

  sfid_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i (tx_push), .data_i (reg_wdata_i),
    .pop_i  (xchg_ok), .data_o (tx_head),
    .level_o(tx_level), .full_o (tx_full), .empty_o(tx_empty)
  );

  sfid_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i (xchg_ok), .data_i (rx_in),
    .pop_i  (rx_pop),  .data_o (rx_head),
    .level_o(rx_level), .full_o (rx_full), .empty_o(rx_empty)
  );

  sfid_regs #(.DW(DW), .DEPTH(DEPTH)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .re_i(reg_re_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .tx_full_i(tx_full), .tx_empty_i(tx_empty), .rx_empty_i(rx_empty),
    .rx_head_i(rx_head),
    .tx_push_o(tx_push), .rx_pop_o(rx_pop),
    .ien_txe_o(ien_txe), .ien_rxr_o(ien_rxr),
    .loop_o(loop_en), .dma_o(dma_cfg)
  );

  sfid_req #(.LVL_W(LVL_W)) u_req (
    .tx_lvl_i(tx_level), .rx_lvl_i(rx_level),
    .ien_txe_i(ien_txe), .ien_rxr_i(ien_rxr), .dma_i(dma_cfg),
    .irq_o, .tx_req_o(tx_dma_req_o), .rx_req_o(rx_dma_req_o),
    .rxt_req_o(rxt_dma_req_o)
  );
endmodule

// File: rtl/sfid_chk.sv
module sfid_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       reg_addr_i,
  input logic             reg_re_i,
  input logic [DW-1:0]    reg_rdata_o,
  input logic             xchg_i,
  input logic             irq_o,
  input logic             tx_dma_req_o,
  input logic             rxt_dma_req_o,
  input logic [LVL_W-1:0] tx_lvl,
  input logic [LVL_W-1:0] rx_lvl
);
  // R3
  tx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_lvl <= LVL_W'(DEPTH));

  // R12
  rx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_lvl <= $past(rx_lvl) + 1'b1);

  // R11
  idle_xchg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xchg_i && tx_lvl == '0 && !(reg_re_i && reg_addr_i == 3'd0)) |=> $stable(rx_lvl));

  // R4
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == 3'd0 && rx_lvl == '0) |-> reg_rdata_o == '0);

  // R6
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (tx_lvl == '0 || rx_lvl != '0));

  // R7
  tx_req_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o |-> tx_lvl != LVL_W'(DEPTH));

  // R9
  tail_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxt_dma_req_o |-> (tx_lvl == '0 && rx_lvl != '0));
endmodule

bind spi_fifo_irq_dma sfid_chk #(.DW(DW), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i, .rst_ni, .reg_addr_i, .reg_re_i, .reg_rdata_o, .xchg_i,
  .irq_o, .tx_dma_req_o, .rxt_dma_req_o,
  .tx_lvl(tx_level), .rx_lvl(rx_level)
);

// File: tb/sim_spi_fifo_irq_dma.sv
`timescale 1ns/1ps
module sim_spi_fifo_irq_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0, xchg = 1'b0;
  logic [31:0] wdata = '0, rx_word = '0;
  logic [31:0] rdata, tx_word;
  logic        irq, txr, rxr, rxtr;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  spi_fifo_irq_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_re_i(re), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .xchg_i(xchg), .rx_word_i(rx_word), .tx_word_o(tx_word),
    .irq_o(irq), .tx_dma_req_o(txr), .rx_dma_req_o(rxr), .rxt_dma_req_o(rxtr)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic xc(input logic [31:0] w);
    @(negedge clk); rx_word = w; xchg = 1'b1;
    @(negedge clk); xchg = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(!irq && !txr && !rxr && !rxtr, "R1 outputs", {irq, txr, rxr, rxtr}, 0);
    rd(3'd4, d); chk(d == 32'h2020_0020, "R1 dma reg", d, 32'h2020_0020);
    rd(3'd3, d); chk(d == 32'h1, "R1 status", d, 32'h1);
    rd(3'd2, d); chk(d == 0, "R1 irq enables", d, 0);
  endtask

  task automatic t_order;
    wr(3'd1, 32'hA1); wr(3'd1, 32'hB2); wr(3'd1, 32'hC3);
    chk(tx_word == 32'hA1, "R2 head 0", tx_word, 32'hA1);
    xc(0); chk(tx_word == 32'hB2, "R2 head 1", tx_word, 32'hB2);
    xc(0); chk(tx_word == 32'hC3, "R2 head 2", tx_word, 32'hC3);
    xc(0); chk(tx_word == 0, "R2 empty head", tx_word, 0);
    for (int i = 0; i < 3; i++) begin
      logic [31:0] d;
      rd(3'd0, d);
    end
  endtask

  task automatic t_full;
    logic [31:0] d;
    for (int i = 0; i < 64; i++) wr(3'd1, 32'h1000 + i);
    rd(3'd3, d); chk(d[7] == 1'b0, "R3 no flag at 64", d, 0);
    wr(3'd1, 32'hDEAD);
    rd(3'd3, d); chk(d[7] == 1'b1, "R3 flag set", d, 32'h80);
    chk(tx_word == 32'h1000, "R3 head kept", tx_word, 32'h1000);
    for (int i = 0; i < 64; i++) xc(32'h2000 + i);
    rd(3'd3, d); chk(d[0] == 1'b1, "R3 dropped word not sent", d, 32'h89);
    wr(3'd1, 32'h55); xc(32'h3333);
    rd(3'd3, d); chk(d[0] == 1'b1, "R12 tx popped", d, 32'h89);
    for (int i = 0; i < 64; i++) begin
      rd(3'd0, d);
      chk(d == 32'h2000 + i, "R12 rx order, extra dropped", d, 32'h2000 + i);
    end
    rd(3'd3, d); chk(d[3] == 1'b0, "R5 drained", d, 0);
    rd(3'd0, d); chk(d == 0, "R4 empty read", d, 0);
    wr(3'd3, 32'h80);
    rd(3'd3, d); chk(d == 32'h1, "R3 flag cleared", d, 32'h1);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    wr(3'd1, 32'h11); xc(32'h77);
    rd(3'd3, d); chk(d[3] == 1'b1, "R5 ready", d, 32'h9);
    rd(3'd0, d); chk(d == 32'h77, "R4 pop value", d, 32'h77);
    rd(3'd3, d); chk(d[3] == 1'b0, "R5 not ready", d, 32'h1);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    chk(!irq, "R6 disabled", irq, 0);
    wr(3'd2, 32'h1); chk(irq, "R6 tx empty irq", irq, 1);
    wr(3'd1, 32'h5); chk(!irq, "R6 tx nonempty", irq, 0);
    wr(3'd2, 32'h8); chk(!irq, "R6 rx empty", irq, 0);
    xc(32'h9); chk(irq, "R6 rx ready irq", irq, 1);
    rd(3'd0, d); chk(!irq, "R6 rx drained", irq, 0);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_dma;
    logic [31:0] d;
    wr(3'd4, 32'h8000_0000 | (32'd1 << 24) | (32'd1 << 23) | (32'd2 << 16) | (32'd1 << 7) | 32'd2);
    chk(txr, "R7 tx req at level 0", txr, 1);
    chk(!rxr, "R8 rx req below wm", rxr, 0);
    chk(!rxtr, "R9 tail rx empty", rxtr, 0);
    wr(3'd1, 1); wr(3'd1, 2); wr(3'd1, 3);
    chk(!txr, "R7 tx req above wm", txr, 0);
    xc(10); xc(11);
    chk(txr, "R7 tx req at wm-1", txr, 1);
    chk(rxr, "R8 rx req at wm", rxr, 1);
    chk(!rxtr, "R9 tail tx busy", rxtr, 0);
    xc(12);
    chk(rxtr, "R9 tail active", rxtr, 1);
    for (int i = 0; i < 3; i++) rd(3'd0, d);
    chk(!rxr && !rxtr, "R8 R9 drained", {rxr, rxtr}, 0);
    wr(3'd4, 32'h2020_0020);
    chk(!txr, "R7 disabled", txr, 0);
  endtask

  task automatic t_loop;
    logic [31:0] d;
    wr(3'd5, 1); wr(3'd1, 32'hAB); xc(32'h55);
    rd(3'd0, d); chk(d == 32'hAB, "R10 loopback", d, 32'hAB);
    wr(3'd5, 0);
    xc(32'h77);
    rd(3'd3, d); chk(d[3] == 1'b0, "R11 idle exchange", d, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_order; t_rx; t_full; t_irq; t_dma; t_loop;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule